// File: doc/BRIEF.md
# I2C Master Bit-Level Engine

This block is the lowest layer of an I2C master. It takes one bus primitive at a time from a sequencing block and produces the matching waveform on open-drain SCL and SDA lines. There are five primitives: a start condition, a stop condition, a byte write with acknowledge sampling, a byte read with a master-driven acknowledge, and a bus-recovery sequence. Each primitive is a fixed list of timing units. One unit lasts `DELAY_CYCLES` clocks, which is a quarter of an SCL period.

The engine never drives a line high. It pulls a line low by asserting that line's output-enable, and it produces a high level by releasing the enable. The SDA line is read back through a two-flop synchronizer. The engine releases SDA whenever the slave is expected to drive it. When a primitive completes, the engine gives a one-clock completion pulse, the acknowledge level it sampled and any byte it read.

Top module: `i2c_bit_engine`

## Requirements
- R1: While reset is held and on the first cycle after it, `scl_oe`, `sda_oe`, `busy` and `done` are 0, and `rdata` and `ack_bit` are 0.
- R2: `cmd_op` is encoded as 0 = start, 1 = stop, 2 = write byte, 3 = read byte, 4 = bus recovery. A command is taken only when `cmd_valid` is 1 and `busy` is 0, and `busy` is 1 from the next cycle. Codes 5 to 7 are ignored and so is `cmd_valid` while `busy` is 1. An ignored request produces no `done`, leaves `busy` at 0 and leaves the lines unchanged.
- R3: Measured in units of `DELAY_CYCLES` clocks, the commands last: start 4, stop 4, write 37, read 29, recovery 40. `done` goes high for exactly one cycle, that many cycles after acceptance, and `busy` is 0 in that cycle.
- R4: A start waits one unit, releases SDA, releases SCL, then pulls SDA low one unit before it ends. SDA falls while SCL is high, and the command ends with SCL high and SDA low.
- R5: A stop pulls SCL low, pulls SDA low, releases SCL and then releases SDA, one unit per step. SDA rises while SCL is high, and both lines end released.
- R6: A write sends `cmd_wdata` most significant bit first. For each bit, SCL goes low, SDA takes the bit one unit later, and SCL is released for two units. During a write, SDA changes only while SCL is low.
- R7: After the eighth bit, SDA is released for a ninth clock. The SDA level seen two units after SCL is released becomes `ack_bit` (0 = acknowledged, 1 = not acknowledged). The command ends with SCL low.
- R8: A read releases SDA and clocks in eight bits, most significant bit first. Each bit is sampled one unit after SCL is released, and the byte is presented on `rdata`.
- R9: After a read the engine drives `cmd_rd_nack` on SDA during a ninth clock. A value of 0 pulls SDA low and a value of 1 releases it. The line is set while SCL is low, and the command ends with SCL low.
- R10: Recovery gives nine SCL pulses (two units low, two units high) with SDA released, then performs the stop of R5. Both lines end released.
- R11: `scl_oe` and `sda_oe` change only at acceptance or at a unit boundary, which is every `DELAY_CYCLES` clocks after acceptance.
- R12: `rdata` and `ack_bit` keep their values after `done` until the next command is accepted. They read 0 in the cycle after an acceptance.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cmd_valid | input | 1 | Command request |
| cmd_op | input | 3 | Command code (see R2) |
| cmd_wdata | input | 8 | Byte to write |
| cmd_rd_nack | input | 1 | Acknowledge level the master drives after a read |
| busy | output | 1 | Command in progress |
| done | output | 1 | One-cycle completion pulse |
| rdata | output | 8 | Byte received by the last read |
| ack_bit | output | 1 | Acknowledge level sampled after the last write |
| sda_in | input | 1 | SDA line level |
| scl_oe | output | 1 | 1 pulls SCL low |
| sda_oe | output | 1 | 1 pulls SDA low |

## Verification
The assertions check the following on every cycle:
- the enables move only at unit boundaries;
- SDA is released and SCL is high whenever the engine samples;
- SDA moves only under a low SCL inside byte transfers;
- SDA stays released through the recovery pulses;
- the command is held while busy, and `done` is a single-cycle pulse.

Only the bench's bus model can show the waveform contents: bit order, start and stop edges, the pulse count, the sampled acknowledge and read data, the exact durations, and that ignored requests leave the bus alone.

// File: rtl/i2c_eng_pkg.sv
package i2c_eng_pkg;

  localparam int IDX_W = 6;

  localparam int WBIT_UNITS     = 4;
  localparam int RBIT_UNITS     = 3;
  localparam int PULSE_UNITS    = 4;
  localparam int RECOVER_PULSES = 9;
  localparam int STOP_UNITS     = 4;

  localparam int UNITS_START   = 4;
  localparam int UNITS_STOP    = STOP_UNITS;
  localparam int WRITE_DATA    = 8 * WBIT_UNITS;
  localparam int READ_DATA     = 8 * RBIT_UNITS;
  localparam int RECOVER_DATA  = RECOVER_PULSES * PULSE_UNITS;
  localparam int UNITS_WRITE   = WRITE_DATA + 5;
  localparam int UNITS_READ    = READ_DATA + 5;
  localparam int UNITS_RECOVER = RECOVER_DATA + STOP_UNITS;

  typedef enum logic [2:0] {
    OP_START   = 3'd0,
    OP_STOP    = 3'd1,
    OP_WRITE   = 3'd2,
    OP_READ    = 3'd3,
    OP_RECOVER = 3'd4
  } op_e;

  typedef struct packed {
    logic scl_set;
    logic scl_low;
    logic sda_set;
    logic sda_low;
    logic sample;
    logic last;
  } unit_act_t;

  function automatic logic op_legal(input logic [2:0] code);
    return code <= 3'd4;
  endfunction

  function automatic unit_act_t stop_unit(input logic [1:0] ph);
    unit_act_t a;
    a = '0;
    case (ph)
      2'd0:    begin a.scl_set = 1'b1; a.scl_low = 1'b1; end
      2'd1:    begin a.sda_set = 1'b1; a.sda_low = 1'b1; end
      2'd2:    begin a.scl_set = 1'b1; a.scl_low = 1'b0; end
      default: begin a.sda_set = 1'b1; a.sda_low = 1'b0; end
    endcase
    return a;
  endfunction

  // Action applied at the start of unit idx of a command.
  function automatic unit_act_t unit_action(input op_e op,
                                            input logic [IDX_W-1:0] idx,
                                            input logic [7:0] wdata,
                                            input logic rd_nack);
    unit_act_t a;
    logic [IDX_W-1:0] tail;
    logic [1:0] rph;
    a    = '0;
    tail = '0;
    rph  = '0;
    case (op)
      OP_START: begin
        case (idx[1:0])
          2'd1:    begin a.sda_set = 1'b1; a.sda_low = 1'b0; end
          2'd2:    begin a.scl_set = 1'b1; a.scl_low = 1'b0; end
          2'd3:    begin a.sda_set = 1'b1; a.sda_low = 1'b1; end
          default: ;
        endcase
        a.last = (idx == IDX_W'(UNITS_START - 1));
      end
      OP_STOP: begin
        a = stop_unit(idx[1:0]);
        a.last = (idx == IDX_W'(UNITS_STOP - 1));
      end
      OP_WRITE: begin
        if (idx < IDX_W'(WRITE_DATA)) begin
          case (idx[1:0])
            2'd0:    begin a.scl_set = 1'b1; a.scl_low = 1'b1; end
            2'd1:    begin a.sda_set = 1'b1; a.sda_low = ~wdata[~idx[4:2]]; end
            2'd2:    begin a.scl_set = 1'b1; a.scl_low = 1'b0; end
            default: ;
          endcase
        end else begin
          tail = idx - IDX_W'(WRITE_DATA);
          case (tail[2:0])
            3'd0:    begin a.scl_set = 1'b1; a.scl_low = 1'b1; end
            3'd1:    begin a.sda_set = 1'b1; a.sda_low = 1'b0; end
            3'd2:    begin a.scl_set = 1'b1; a.scl_low = 1'b0; end
            3'd3:    a.sample = 1'b1;
            default: begin a.scl_set = 1'b1; a.scl_low = 1'b1; a.last = 1'b1; end
          endcase
        end
      end
      OP_READ: begin
        if (idx < IDX_W'(READ_DATA)) begin
          rph = 2'(idx % IDX_W'(RBIT_UNITS));
          case (rph)
            2'd0: begin
              a.scl_set = 1'b1; a.scl_low = 1'b1;
              a.sda_set = 1'b1; a.sda_low = 1'b0;
            end
            2'd1:    begin a.scl_set = 1'b1; a.scl_low = 1'b0; a.sample = 1'b1; end
            default: ;
          endcase
        end else begin
          tail = idx - IDX_W'(READ_DATA);
          case (tail[2:0])
            3'd0:    begin a.scl_set = 1'b1; a.scl_low = 1'b1; end
            3'd1:    begin a.sda_set = 1'b1; a.sda_low = ~rd_nack; end
            3'd2:    begin a.scl_set = 1'b1; a.scl_low = 1'b0; end
            3'd3:    ;
            default: begin a.scl_set = 1'b1; a.scl_low = 1'b1; a.last = 1'b1; end
          endcase
        end
      end
      OP_RECOVER: begin
        if (idx < IDX_W'(RECOVER_DATA)) begin
          case (idx[1:0])
            2'd0: begin
              a.scl_set = 1'b1; a.scl_low = 1'b1;
              a.sda_set = 1'b1; a.sda_low = 1'b0;
            end
            2'd2:    begin a.scl_set = 1'b1; a.scl_low = 1'b0; end
            default: ;
          endcase
        end else begin
          tail = idx - IDX_W'(RECOVER_DATA);
          a = stop_unit(tail[1:0]);
          a.last = (tail[1:0] == 2'd3);
        end
      end
      default: a.last = 1'b1;
    endcase
    return a;
  endfunction

endpackage

// File: rtl/i2c_eng_tick.sv
module i2c_eng_tick #(
  parameter int DELAY_CYCLES = 250
) (
  input  logic clk,
  input  logic rst_n,
  input  logic restart,
  input  logic run,
  output logic tick
);
  localparam int CNT_W = (DELAY_CYCLES > 1) ? $clog2(DELAY_CYCLES) : 1;
  localparam logic [CNT_W-1:0] RELOAD = CNT_W'(DELAY_CYCLES - 1);

  logic [CNT_W-1:0] cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                 cnt <= RELOAD;
    else if (restart)           cnt <= RELOAD;
    else if (run) begin
      if (cnt == '0)            cnt <= RELOAD;
      else                      cnt <= cnt - 1'b1;
    end
  end

  assign tick = run && !restart && (cnt == '0);

endmodule

// File: rtl/i2c_eng_sync.sv
module i2c_eng_sync #(
  parameter int   STAGES    = 2,
  parameter logic RESET_VAL = 1'b1
) (
  input  logic clk,
  input  logic rst_n,
  input  logic d,
  output logic q
);
  logic [STAGES-1:0] chain;

  generate
    if (STAGES == 1) begin : g_one
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) chain <= RESET_VAL;
        else        chain <= d;
      end
    end else begin : g_many
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) chain <= {STAGES{RESET_VAL}};
        else        chain <= {chain[STAGES-2:0], d};
      end
    end
  endgenerate

  assign q = chain[STAGES-1];

endmodule

// File: rtl/i2c_eng_seq.sv
module i2c_eng_seq
  import i2c_eng_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       cmd_valid,
  input  logic [2:0] cmd_op,
  input  logic [7:0] cmd_wdata,
  input  logic       cmd_rd_nack,
  input  logic       tick,
  input  logic       sda_line,
  output logic       accept,
  output logic       busy,
  output logic       done,
  output logic [7:0] rdata,
  output logic       ack_bit,
  output logic       scl_oe,
  output logic       sda_oe
);
  op_e              op_q;
  logic [IDX_W-1:0] idx_q;
  logic [7:0]       wdata_q;
  logic             nack_q;

  unit_act_t act_first, act_cur, act_next;
  logic      unit_end, sample_now, finish_now;

  assign accept     = cmd_valid && !busy && op_legal(cmd_op);
  assign act_first  = unit_action(op_e'(cmd_op), '0, cmd_wdata, cmd_rd_nack);
  assign act_cur    = unit_action(op_q, idx_q, wdata_q, nack_q);
  assign act_next   = unit_action(op_q, idx_q + IDX_W'(1), wdata_q, nack_q);
  assign unit_end   = busy && tick;
  assign sample_now = unit_end && act_cur.sample;
  assign finish_now = unit_end && act_cur.last;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy    <= 1'b0;
      done    <= 1'b0;
      op_q    <= OP_START;
      idx_q   <= '0;
      wdata_q <= '0;
      nack_q  <= 1'b0;
      rdata   <= '0;
      ack_bit <= 1'b0;
      scl_oe  <= 1'b0;
      sda_oe  <= 1'b0;
    end else begin
      done <= 1'b0;
      if (accept) begin
        busy    <= 1'b1;
        op_q    <= op_e'(cmd_op);
        idx_q   <= '0;
        wdata_q <= cmd_wdata;
        nack_q  <= cmd_rd_nack;
        rdata   <= '0;
        ack_bit <= 1'b0;
        if (act_first.scl_set) scl_oe <= act_first.scl_low;
        if (act_first.sda_set) sda_oe <= act_first.sda_low;
      end else if (unit_end) begin
        if (sample_now) begin
          if (op_q == OP_READ) rdata   <= {rdata[6:0], sda_line};
          else                 ack_bit <= sda_line;
        end
        if (finish_now) begin
          busy <= 1'b0;
          done <= 1'b1;
        end else begin
          idx_q <= idx_q + IDX_W'(1);
          if (act_next.scl_set) scl_oe <= act_next.scl_low;
          if (act_next.sda_set) sda_oe <= act_next.sda_low;
        end
      end
    end
  end

  // R3: completion pulse lasts one cycle and comes with busy low
  a_r3_done_single: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);
  a_r3_done_idle: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !busy);

  // R2: the command in flight cannot be replaced while busy
  a_r2_cmd_locked: assert property (@(posedge clk) disable iff (!rst_n)
    busy |=> (!busy || ($stable(op_q) && $stable(wdata_q))));

  // R11: enables move only at acceptance or a unit boundary
  a_r11_unit_edges: assert property (@(posedge clk) disable iff (!rst_n)
    !(accept || unit_end) |=> $stable({scl_oe, sda_oe}));

  // R7, R8: sampling happens with SDA released and SCL high
  a_r7_sda_free_on_sample: assert property (@(posedge clk) disable iff (!rst_n)
    sample_now |-> !sda_oe);
  a_r8_scl_high_on_sample: assert property (@(posedge clk) disable iff (!rst_n)
    sample_now |-> !scl_oe);

  // R6: inside byte transfers SDA only moves under a low SCL
  a_r6_sda_under_low_scl: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && (op_q == OP_WRITE || op_q == OP_READ) && !$stable(sda_oe)) |-> scl_oe);

  // R10: SDA stays released through the recovery pulses
  a_r10_sda_free: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && op_q == OP_RECOVER && idx_q < IDX_W'(RECOVER_DATA)) |-> !sda_oe);

endmodule

// File: rtl/i2c_bit_engine.sv
module i2c_bit_engine #(
  parameter int DELAY_CYCLES = 250,
  parameter int SYNC_STAGES  = 2
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       cmd_valid,
  input  logic [2:0] cmd_op,
  input  logic [7:0] cmd_wdata,
  input  logic       cmd_rd_nack,
  output logic       busy,
  output logic       done,
  output logic [7:0] rdata,
  output logic       ack_bit,
  input  logic       sda_in,
  output logic       scl_oe,
  output logic       sda_oe
);
  logic accept;
  logic tick;
  logic sda_line;

  i2c_eng_sync #(.STAGES(SYNC_STAGES), .RESET_VAL(1'b1)) u_sda_sync (
    .clk   (clk),
    .rst_n (rst_n),
    .d     (sda_in),
    .q     (sda_line)
  );

  i2c_eng_tick #(.DELAY_CYCLES(DELAY_CYCLES)) u_tick (
    .clk     (clk),
    .rst_n   (rst_n),
    .restart (accept),
    .run     (busy),
    .tick    (tick)
  );

  i2c_eng_seq u_seq (
    .clk         (clk),
    .rst_n       (rst_n),
    .cmd_valid   (cmd_valid),
    .cmd_op      (cmd_op),
    .cmd_wdata   (cmd_wdata),
    .cmd_rd_nack (cmd_rd_nack),
    .tick        (tick),
    .sda_line    (sda_line),
    .accept      (accept),
    .busy        (busy),
    .done        (done),
    .rdata       (rdata),
    .ack_bit     (ack_bit),
    .scl_oe      (scl_oe),
    .sda_oe      (sda_oe)
  );

endmodule

// File: tb/i2c_bit_engine_test.sv
`timescale 1ns/1ps
module i2c_bit_engine_test;
  localparam int D = 4;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #5 clk = ~clk;

  logic       cmd_valid = 1'b0;
  logic [2:0] cmd_op = 3'd0;
  logic [7:0] cmd_wdata = 8'h00;
  logic       cmd_rd_nack = 1'b0;
  logic       busy, done, ack_bit, scl_oe, sda_oe;
  logic [7:0] rdata;

  // slave model: mode 0 idle, 1 acknowledges a write, 2 returns a byte
  logic [1:0] s_mode = 2'd0;
  logic [7:0] s_byte = 8'h00;
  logic       s_ack  = 1'b0;
  int         s_idx  = 0;

  wire scl_line  = ~scl_oe;
  wire slave_low = (s_mode == 2'd1 && s_idx == 8 && s_ack) ||
                   (s_mode == 2'd2 && s_idx < 8 && !s_byte[3'(7 - s_idx)]);
  wire sda_line  = ~sda_oe & ~slave_low;

  i2c_bit_engine #(.DELAY_CYCLES(D)) uut (
    .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_op(cmd_op),
    .cmd_wdata(cmd_wdata), .cmd_rd_nack(cmd_rd_nack), .busy(busy),
    .done(done), .rdata(rdata), .ack_bit(ack_bit), .sda_in(sda_line),
    .scl_oe(scl_oe), .sda_oe(sda_oe)
  );

  int checks = 0;
  int errors = 0;

  task automatic check_eq(input string req, input string what, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  typedef struct packed {
    logic [2:0] op;
    logic [7:0] wd;
    logic       nack;
    logic [1:0] smode;
    logic [7:0] sb;
    logic       sa;
    logic [7:0] erd;
    logic       eack;
    logic [8:0] ecap;
    logic [3:0] erise;
    logic [5:0] eunits;
    logic       escl;
    logic       esda;
    logic [1:0] ehi;
  } vec_t;

  localparam vec_t VECS [9] = '{
    '{3'd0, 8'h00, 1'b0, 2'd0, 8'h00, 1'b0, 8'h00, 1'b0, 9'h000, 4'd0,  6'd4,  1'b1, 1'b0, 2'd1},
    '{3'd2, 8'hA4, 1'b0, 2'd1, 8'h00, 1'b1, 8'h00, 1'b0, 9'h148, 4'd9,  6'd37, 1'b0, 1'b1, 2'd0},
    '{3'd2, 8'h3C, 1'b0, 2'd1, 8'h00, 1'b0, 8'h00, 1'b1, 9'h079, 4'd9,  6'd37, 1'b0, 1'b1, 2'd0},
    '{3'd0, 8'h00, 1'b0, 2'd0, 8'h00, 1'b0, 8'h00, 1'b0, 9'h001, 4'd1,  6'd4,  1'b1, 1'b0, 2'd1},
    '{3'd2, 8'hA5, 1'b0, 2'd1, 8'h00, 1'b1, 8'h00, 1'b0, 9'h14A, 4'd9,  6'd37, 1'b0, 1'b1, 2'd0},
    '{3'd3, 8'h00, 1'b0, 2'd2, 8'h96, 1'b0, 8'h96, 1'b0, 9'h12C, 4'd9,  6'd29, 1'b0, 1'b0, 2'd0},
    '{3'd3, 8'h00, 1'b1, 2'd2, 8'h5A, 1'b0, 8'h5A, 1'b0, 9'h0B5, 4'd9,  6'd29, 1'b0, 1'b1, 2'd0},
    '{3'd1, 8'h00, 1'b0, 2'd0, 8'h00, 1'b0, 8'h00, 1'b0, 9'h000, 4'd1,  6'd4,  1'b1, 1'b1, 2'd1},
    '{3'd4, 8'h00, 1'b0, 2'd0, 8'h00, 1'b0, 8'h00, 1'b0, 9'h1FE, 4'd10, 6'd40, 1'b1, 1'b1, 2'd1}
  };

  function automatic string wave_tag(input logic [2:0] op);
    case (op)
      3'd0: return "R4";
      3'd1: return "R5";
      3'd2: return "R6/R7";
      3'd3: return "R8/R9";
      default: return "R10";
    endcase
  endfunction

  task automatic run_cmd(input vec_t v);
    int cyc, rises, hi, mis, dcnt;
    logic [8:0] cap;
    logic ps, pd, cs, cd;
    logic [1:0] poe;
    @(negedge clk);
    cmd_valid = 1'b1; cmd_op = v.op; cmd_wdata = v.wd; cmd_rd_nack = v.nack;
    s_mode = v.smode; s_byte = v.sb; s_ack = v.sa; s_idx = 0;
    ps = scl_line; pd = sda_line; poe = {scl_oe, sda_oe};
    rises = 0; hi = 0; mis = 0; dcnt = 0; cap = '0;
    @(negedge clk);
    cmd_valid = 1'b0;
    cyc = 1;
    check_eq("R2", "busy after request", int'(busy), 1);
    check_eq("R12", "rdata cleared on accept", int'(rdata), 0);
    check_eq("R12", "ack cleared on accept", int'(ack_bit), 0);
    forever begin
      cs = scl_line; cd = sda_line;
      if ({scl_oe, sda_oe} != poe && ((cyc - 1) % D) != 0) mis++;
      if (!ps && cs) begin rises++; cap = {cap[7:0], cd}; end
      if (ps && cs && (pd != cd)) hi++;
      if (ps && !cs) s_idx = rises;
      ps = cs; pd = cd; poe = {scl_oe, sda_oe};
      if (done) begin dcnt++; break; end
      if (cyc > 2000) break;
      @(negedge clk);
      cyc++;
    end
    check_eq("R3", "command cycles", cyc - 1, int'(v.eunits) * D);
    check_eq("R3", "done seen", dcnt, 1);
    check_eq("R3", "busy at done", int'(busy), 0);
    check_eq(wave_tag(v.op), "SCL rising edges", rises, int'(v.erise));
    check_eq(wave_tag(v.op), "SDA at SCL rises", int'(cap), int'(v.ecap));
    check_eq(wave_tag(v.op), "SDA moves with SCL high", hi, int'(v.ehi));
    check_eq(wave_tag(v.op), "final SCL", int'(scl_line), int'(v.escl));
    check_eq(wave_tag(v.op), "final SDA", int'(sda_line), int'(v.esda));
    check_eq("R8", "rdata", int'(rdata), int'(v.erd));
    check_eq("R7", "ack_bit", int'(ack_bit), int'(v.eack));
    check_eq("R11", "enable change off unit boundary", mis, 0);
    @(negedge clk);
    check_eq("R3", "done one cycle", int'(done), 0);
    repeat (4) @(negedge clk);
    check_eq("R12", "rdata held", int'(rdata), int'(v.erd));
    check_eq("R12", "ack_bit held", int'(ack_bit), int'(v.eack));
  endtask

  initial begin : watchdog
    #1_000_000;
    errors++;
    $display("FAIL R3 watchdog: actual no completion expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin : main
    int dn, bz, moved;
    // R1 reset state
    repeat (3) @(negedge clk);
    check_eq("R1", "scl_oe in reset", int'(scl_oe), 0);
    check_eq("R1", "sda_oe in reset", int'(sda_oe), 0);
    check_eq("R1", "busy in reset", int'(busy), 0);
    rst_n = 1'b1;
    @(negedge clk);
    check_eq("R1", "done after reset", int'(done), 0);
    check_eq("R1", "rdata after reset", int'(rdata), 0);
    check_eq("R1", "ack after reset", int'(ack_bit), 0);
    check_eq("R1", "lines after reset", int'({scl_oe, sda_oe}), 0);

    for (int i = 0; i < 9; i++) run_cmd(VECS[i]);

    // R2 illegal code is ignored
    @(negedge clk);
    cmd_valid = 1'b1; cmd_op = 3'd6;
    @(negedge clk);
    cmd_valid = 1'b0;
    dn = 0; bz = 0; moved = 0;
    for (int k = 0; k < 20; k++) begin
      if (done) dn++;
      if (busy) bz++;
      if (scl_oe || sda_oe) moved++;
      @(negedge clk);
    end
    check_eq("R2", "illegal code busy cycles", bz, 0);
    check_eq("R2", "illegal code done", dn, 0);
    check_eq("R2", "illegal code moved lines", moved, 0);

    // R2 request while busy is ignored
    cmd_valid = 1'b1; cmd_op = 3'd0; s_mode = 2'd0;
    @(negedge clk);
    cmd_valid = 1'b0;
    repeat (3) @(negedge clk);
    cmd_valid = 1'b1; cmd_op = 3'd1;
    @(negedge clk);
    cmd_valid = 1'b0;
    dn = 0;
    for (int k = 0; k < 60; k++) begin
      if (done) dn++;
      @(negedge clk);
    end
    check_eq("R2", "done count with request while busy", dn, 1);
    check_eq("R2", "SCL after ignored stop", int'(scl_line), 1);
    check_eq("R2", "SDA after ignored stop", int'(sda_line), 0);
    check_eq("R2", "busy after ignored stop", int'(busy), 0);

    run_cmd(VECS[7]);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule